// File: doc/BRIEF.md
# Five-Stage Line-Numbered Pipelined Processor

This block is a small in-order processor that runs a program held in an instruction ROM whose words are addressed by line number. Each instruction passes through five stages in order: fetch, decode, operand read, execute and write-back. There is no separate memory stage. Loads and stores reach a word-addressed data memory during execute. The ISA has six operations: register add, add-immediate, load, store, an unconditional jump, and a jump taken only when a register holds a nonzero value. Jump targets are absolute line numbers.

An instruction in operand read whose source register is still owed by an older instruction in execute or write-back waits there. A bubble goes into execute while it waits. A taken jump is resolved in execute. It discards the three younger stages, and fetch restarts at the target line on the next cycle. The program and the initial data memory contents are parameters.

The core raises `done` once fetch has run past the last line and the pipeline has drained. Debug outputs show the next fetch line, which stages are occupied, and a trace of every instruction as it leaves write-back.

Top module: `line_pipe_core`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, the next-fetch line is 1, the occupancy vector is 0, `done_o` is 0, `ret_valid_o` is 0, every register reads 0, and data word i holds `DINIT[i]`.
- R2: An instruction word is 28 bits: opcode [27:24], register A [23:20], register B [19:16], register C [15:12], and N/address/line [15:0]. Opcode 1 (add) writes B+C into A. Opcode 2 (addi) writes B+N into A. Opcodes 0 and 7–15 do nothing. All arithmetic is 16-bit and wraps.
- R3: Opcode 3 (load) copies data word N into A. Opcode 4 (store) writes A into data word N. An address at or above `DWORDS` reads as 0 and is not written.
- R4: Opcode 5 (goto) makes line N the next instruction. Opcode 6 (if) does the same only when A is nonzero, and otherwise falls through to the next line.
- R5: Lines are numbered from 1, and one line is fetched per cycle. A program of N lines with no dependences and no jumps raises `done_o` N+6 rising edges after reset is released.
- R6: If an instruction in operand read has a source register that an instruction in execute or write-back is going to write, it holds in place and execute receives a bubble. Each dependence between adjacent lines costs two cycles.
- R7: A taken jump discards fetch, decode and operand read on the edge that follows its execute cycle. On that edge `pc_o` becomes the target, and the target is fetched on the next edge.
- R8: `done_o` rises one edge after the pipeline is empty with the next-fetch line outside 1..NLINES. It then stays high.
- R9: Every executed instruction appears exactly once on the retire port, in program order. The port shows its line, its register write (`ret_we_o`, `ret_reg_o`, `ret_val_o`), or its store (`ret_st_o`, `ret_addr_o`, with the stored value on `ret_val_o`). Discarded instructions never appear.
- R10: `occ_o` bit 0 is fetch, bit 1 decode, bit 2 operand read, bit 3 execute and bit 4 write-back. A bit is 1 when that stage holds an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_o | output | 1 | Program finished, sticky |
| pc_o | output | 16 | Next line to fetch |
| occ_o | output | 5 | Per-stage occupancy (bit 0 fetch … bit 4 write-back) |
| ret_valid_o | output | 1 | An instruction is in write-back this cycle |
| ret_line_o | output | 16 | Line of the retiring instruction |
| ret_we_o | output | 1 | Retiring instruction writes a register |
| ret_reg_o | output | 4 | Destination register |
| ret_st_o | output | 1 | Retiring instruction was a store |
| ret_addr_o | output | 16 | Store address |
| ret_val_o | output | 16 | Written or stored value |

## Verification
The bench sends a chain of back-to-back dependent adds through the core. A core that lets a reader pass operand read early would retire stale sums. A core that stalls too long or too briefly would miss the exact cycle count to `done`.

A jump-over program checks that the flushed lines never retire and that occupancy collapses to write-back alone on the flush edge. A countdown loop sends the conditional jump through both its taken and its fall-through cases, with a negative immediate. The same loop would expose a wrong test of zero, or a duplicated or lost retirement.

A load/branch program whose data comes from the initial memory image checks load-use stalls and store contents, against an in-bench sequential interpreter of the ISA.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int XW  = 16;
  localparam int RFW = 4;
  localparam int IW  = 28;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDI  = 4'd2,
    OP_LOAD  = 4'd3,
    OP_STORE = 4'd4,
    OP_GOTO  = 4'd5,
    OP_IF    = 4'd6
  } op_e;

  typedef struct packed {
    logic          valid;
    logic [XW-1:0] line;
    logic [IW-1:0] word;
  } fslot_t;

  typedef struct packed {
    logic           valid;
    logic [XW-1:0]  line;
    op_e            op;
    logic [RFW-1:0] dst;
    logic [RFW-1:0] s1;
    logic [RFW-1:0] s2;
    logic           use1;
    logic           use2;
    logic           wr;
    logic [XW-1:0]  imm;
  } dslot_t;

  typedef struct packed {
    logic           valid;
    logic [XW-1:0]  line;
    op_e            op;
    logic [RFW-1:0] dst;
    logic           wr;
    logic [XW-1:0]  imm;
    logic [XW-1:0]  v1;
    logic [XW-1:0]  v2;
  } xslot_t;

  typedef struct packed {
    logic           valid;
    logic [XW-1:0]  line;
    logic           wr;
    logic [RFW-1:0] dst;
    logic           st;
    logic [XW-1:0]  addr;
    logic [XW-1:0]  val;
  } wslot_t;

  function automatic dslot_t decode(input fslot_t f);
    dslot_t d;
    d.valid = f.valid;
    d.line  = f.line;
    d.op    = OP_NOP;
    d.dst   = f.word[23:20];
    d.s1    = '0;
    d.s2    = '0;
    d.use1  = 1'b0;
    d.use2  = 1'b0;
    d.wr    = 1'b0;
    d.imm   = f.word[15:0];
    case (f.word[27:24])
      4'd1: begin
        d.op = OP_ADD; d.s1 = f.word[19:16]; d.s2 = f.word[15:12];
        d.use1 = 1'b1; d.use2 = 1'b1; d.wr = 1'b1;
      end
      4'd2: begin
        d.op = OP_ADDI; d.s1 = f.word[19:16]; d.use1 = 1'b1; d.wr = 1'b1;
      end
      4'd3: begin
        d.op = OP_LOAD; d.wr = 1'b1;
      end
      4'd4: begin
        d.op = OP_STORE; d.s1 = f.word[23:20]; d.use1 = 1'b1;
      end
      4'd5: d.op = OP_GOTO;
      4'd6: begin
        d.op = OP_IF; d.s1 = f.word[23:20]; d.use1 = 1'b1;
      end
      default: d.op = OP_NOP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lp_regfile.sv
module lp_regfile
  import lp_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RFW-1:0] ra1,
  input  logic [RFW-1:0] ra2,
  output logic [XW-1:0]  rd1,
  output logic [XW-1:0]  rd2,
  input  logic           we,
  input  logic [RFW-1:0] wa,
  input  logic [XW-1:0]  wd
);
  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NREG; i++)
        if (wa == RFW'(i)) regs[i] <= wd;
    end
  end

  always_comb begin
    rd1 = '0;
    rd2 = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ra1 == RFW'(i)) rd1 = regs[i];
      if (ra2 == RFW'(i)) rd2 = regs[i];
    end
  end
endmodule

// File: rtl/lp_dmem.sv
module lp_dmem
  import lp_pkg::*;
#(
  parameter int DWORDS = 16,
  parameter logic [XW-1:0] DINIT [DWORDS] = '{default: '0}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [XW-1:0] waddr,
  input  logic [XW-1:0] wdata,
  input  logic [XW-1:0] raddr,
  output logic [XW-1:0] rdata
);
  logic [XW-1:0] mem [DWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DWORDS; i++) mem[i] <= DINIT[i];
    end else if (we) begin
      for (int i = 0; i < DWORDS; i++)
        if (waddr == XW'(i)) mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DWORDS; i++)
      if (raddr == XW'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/lp_hazard.sv
module lp_hazard
  import lp_pkg::*;
#(
  parameter int NPROD = 2
) (
  input  logic                       rd_valid,
  input  logic                       use1,
  input  logic                       use2,
  input  logic [RFW-1:0]             s1,
  input  logic [RFW-1:0]             s2,
  input  logic [NPROD-1:0]           p_valid,
  input  logic [NPROD-1:0]           p_wr,
  input  logic [NPROD-1:0][RFW-1:0]  p_dst,
  output logic                       hit
);
  logic [NPROD-1:0] owed;

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    assign owed[g] = p_valid[g] && p_wr[g] &&
                     ((use1 && (s1 == p_dst[g])) || (use2 && (s2 == p_dst[g])));
  end

  assign hit = rd_valid && (|owed);
endmodule

// File: rtl/line_pipe_core.sv
module line_pipe_core
  import lp_pkg::*;
#(
  parameter int NLINES = 11,
  parameter int DWORDS = 16,
  parameter int NREG   = 16,
  parameter logic [IW-1:0] PROG [NLINES] = '{
    28'h3100001, 28'h2310014, 28'h3200002, 28'h6200006,
    28'h1212000, 28'h2520032, 28'h2610014, 28'h271001E,
    28'h470000A, 28'h460000B, 28'h450000C},
  parameter logic [XW-1:0] DINIT [DWORDS] = '{1: 16'd10, 2: 16'd5, default: 16'd0}
) (
  input  logic           clk,
  input  logic           rst,
  output logic           done_o,
  output logic [XW-1:0]  pc_o,
  output logic [4:0]     occ_o,
  output logic           ret_valid_o,
  output logic [XW-1:0]  ret_line_o,
  output logic           ret_we_o,
  output logic [RFW-1:0] ret_reg_o,
  output logic           ret_st_o,
  output logic [XW-1:0]  ret_addr_o,
  output logic [XW-1:0]  ret_val_o
);
  localparam logic [XW-1:0] LAST = XW'(NLINES);

  logic [XW-1:0] pc;
  fslot_t f_q;
  dslot_t d_q, o_q;
  xslot_t e_q;
  wslot_t w_q;
  logic   done_q;

  logic          fetch_ok, taken, stall, hazard, mem_we;
  logic [XW-1:0] rf_a, rf_b, mem_rd, ex_val;

  function automatic logic [IW-1:0] rom_word(input logic [XW-1:0] ln);
    logic [IW-1:0] w;
    w = '0;
    for (int i = 0; i < NLINES; i++)
      if (ln == XW'(i + 1)) w = PROG[i];
    return w;
  endfunction

  assign fetch_ok = (pc != '0) && (pc <= LAST);

  lp_regfile #(.NREG(NREG)) u_rf (
    .clk (clk), .rst (rst),
    .ra1 (o_q.s1), .ra2 (o_q.s2),
    .rd1 (rf_a),   .rd2 (rf_b),
    .we  (w_q.valid && w_q.wr), .wa (w_q.dst), .wd (w_q.val)
  );

  lp_hazard #(.NPROD(2)) u_hz (
    .rd_valid (o_q.valid),
    .use1     (o_q.use1), .use2 (o_q.use2),
    .s1       (o_q.s1),   .s2   (o_q.s2),
    .p_valid  ({w_q.valid, e_q.valid}),
    .p_wr     ({w_q.wr, e_q.wr}),
    .p_dst    ({w_q.dst, e_q.dst}),
    .hit      (hazard)
  );

  assign mem_we = e_q.valid && (e_q.op == OP_STORE);

  lp_dmem #(.DWORDS(DWORDS), .DINIT(DINIT)) u_dm (
    .clk   (clk), .rst (rst),
    .we    (mem_we), .waddr (e_q.imm), .wdata (e_q.v1),
    .raddr (e_q.imm), .rdata (mem_rd)
  );

  always_comb begin
    case (e_q.op)
      OP_ADD:   ex_val = e_q.v1 + e_q.v2;
      OP_ADDI:  ex_val = e_q.v1 + e_q.imm;
      OP_LOAD:  ex_val = mem_rd;
      OP_STORE: ex_val = e_q.v1;
      default:  ex_val = '0;
    endcase
  end

  assign taken = e_q.valid &&
                 ((e_q.op == OP_GOTO) || ((e_q.op == OP_IF) && (e_q.v1 != '0)));
  assign stall = hazard && !taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= XW'(1);
      f_q    <= '0;
      d_q    <= '0;
      o_q    <= '0;
      e_q    <= '0;
      w_q    <= '0;
      done_q <= 1'b0;
    end else begin
      w_q.valid <= e_q.valid;
      w_q.line  <= e_q.line;
      w_q.wr    <= e_q.wr;
      w_q.dst   <= e_q.dst;
      w_q.st    <= (e_q.op == OP_STORE);
      w_q.addr  <= e_q.imm;
      w_q.val   <= ex_val;
      done_q    <= done_q || (!fetch_ok && !f_q.valid && !d_q.valid &&
                              !o_q.valid && !e_q.valid && !w_q.valid);
      if (taken) begin
        f_q.valid <= 1'b0;
        d_q.valid <= 1'b0;
        o_q.valid <= 1'b0;
        e_q.valid <= 1'b0;
        pc        <= e_q.imm;
      end else if (stall) begin
        e_q.valid <= 1'b0;
      end else begin
        e_q.valid <= o_q.valid;
        e_q.line  <= o_q.line;
        e_q.op    <= o_q.op;
        e_q.dst   <= o_q.dst;
        e_q.wr    <= o_q.wr;
        e_q.imm   <= o_q.imm;
        e_q.v1    <= rf_a;
        e_q.v2    <= rf_b;
        o_q       <= d_q;
        d_q       <= decode(f_q);
        f_q.valid <= fetch_ok;
        f_q.line  <= pc;
        f_q.word  <= rom_word(pc);
        if (fetch_ok) pc <= pc + XW'(1);
      end
    end
  end

  assign done_o      = done_q;
  assign pc_o        = pc;
  assign occ_o       = {w_q.valid, e_q.valid, o_q.valid, d_q.valid, f_q.valid};
  assign ret_valid_o = w_q.valid;
  assign ret_line_o  = w_q.line;
  assign ret_we_o    = w_q.valid && w_q.wr;
  assign ret_reg_o   = w_q.dst;
  assign ret_st_o    = w_q.valid && w_q.st;
  assign ret_addr_o  = w_q.addr;
  assign ret_val_o   = w_q.val;

  // R6: a held reader leaves an empty execute slot behind it
  a_r6_stall_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> !e_q.valid);
  // R6: the held reader stays in operand read
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (o_q.valid && $stable(o_q.line)));
  // R7: the three younger stages are empty after a taken jump
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
    taken |=> (!f_q.valid && !d_q.valid && !o_q.valid));
  // R8: done never drops once raised
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  // R8: done only with an empty pipeline
  a_r8_done_empty: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (occ_o == 5'b0));
  // R9: a retiring instruction never writes a register and memory at once
  a_r9_one_effect: assert property (@(posedge clk) disable iff (rst)
    ret_valid_o |-> !(ret_we_o && ret_st_o));
endmodule

// File: tb/line_pipe_core_tb_top.sv
module lp_probe #(
  parameter int NL = 1,
  parameter logic [27:0] PROG [NL] = '{default: '0},
  parameter logic [15:0] DI [16] = '{default: '0},
  parameter int EXP_CYC = -1,
  parameter string TAGC = "R5",
  parameter string NAME = "prog"
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        done,
  input  logic [15:0] pc,
  input  logic [4:0]  occ,
  input  logic        ret_valid,
  input  logic [15:0] ret_line,
  input  logic        ret_we,
  input  logic [3:0]  ret_reg,
  input  logic        ret_st,
  input  logic [15:0] ret_addr,
  input  logic [15:0] ret_val,
  output int          n_chk,
  output int          n_err,
  output logic        fin
);
  int    e_line [64];
  bit    e_we   [64];
  bit    e_st   [64];
  int    e_reg  [64];
  int    e_val  [64];
  int    e_addr [64];
  string e_tag  [64];
  int    e_n = 0;
  int    chk = 0, err = 0, rcnt = 0, cyc = 0, k = 0, post = 0;
  bit    seen = 0, fin_r = 0;

  assign n_chk = chk;
  assign n_err = err;
  assign fin   = fin_r;

  initial begin : model
    logic [15:0] r [16];
    logic [15:0] m [16];
    logic [27:0] w;
    int p, nxt, steps, a, b, c, x, op;
    for (int i = 0; i < 16; i++) begin r[i] = '0; m[i] = DI[i]; end
    p = 1; steps = 0;
    while (p >= 1 && p <= NL && steps < 60) begin
      w = PROG[p-1];
      op = int'(w[27:24]); a = int'(w[23:20]); b = int'(w[19:16]);
      c = int'(w[15:12]); x = int'(w[15:0]);
      nxt = p + 1;
      e_line[e_n] = p; e_we[e_n] = 0; e_st[e_n] = 0; e_reg[e_n] = a;
      e_val[e_n] = 0; e_addr[e_n] = x; e_tag[e_n] = "R4";
      case (op)
        1: begin e_val[e_n] = int'(16'(r[b] + r[c])); e_we[e_n] = 1; e_tag[e_n] = "R2"; end
        2: begin e_val[e_n] = int'(16'(r[b] + 16'(x))); e_we[e_n] = 1; e_tag[e_n] = "R2"; end
        3: begin e_val[e_n] = (x < 16) ? int'(m[x]) : 0; e_we[e_n] = 1; e_tag[e_n] = "R3"; end
        4: begin e_val[e_n] = int'(r[a]); e_st[e_n] = 1; e_tag[e_n] = "R3";
                 if (x < 16) m[x] = r[a]; end
        5: nxt = x;
        6: if (r[a] != 0) nxt = x;
        default: e_tag[e_n] = "R2";
      endcase
      if (e_we[e_n]) r[a] = 16'(e_val[e_n]);
      e_n++; p = nxt; steps++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s %s %s: got %0d expected %0d", NAME, req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      rcnt++;
      if (rcnt == 2) begin
        check(pc == 16'd1, "R1", "reset pc", int'(pc), 1);
        check(occ == 5'd0, "R1", "reset occupancy", int'(occ), 0);
        check(!done, "R1", "reset done", int'(done), 0);
        check(!ret_valid, "R1", "reset retire", int'(ret_valid), 0);
      end
    end else if (!fin_r) begin
      cyc++;
      if (ret_valid) begin
        if (k < e_n) begin
          check(int'(ret_line) == e_line[k], "R9", "retire line", int'(ret_line), e_line[k]);
          check(ret_we == e_we[k], "R9", "retire write flag", int'(ret_we), int'(e_we[k]));
          check(ret_st == e_st[k], "R9", "retire store flag", int'(ret_st), int'(e_st[k]));
          if (e_we[k]) begin
            check(int'(ret_reg) == e_reg[k], e_tag[k], "dest reg", int'(ret_reg), e_reg[k]);
            check(int'(ret_val) == e_val[k], e_tag[k], "written value", int'(ret_val), e_val[k]);
          end
          if (e_st[k]) begin
            check(int'(ret_addr) == e_addr[k], "R3", "store address", int'(ret_addr), e_addr[k]);
            check(int'(ret_val) == e_val[k], "R3", "stored value", int'(ret_val), e_val[k]);
          end
        end else begin
          check(1'b0, "R9", "extra retirement line", int'(ret_line), 0);
        end
        k++;
      end
      if (done && !seen) begin
        seen = 1;
        check(k == e_n, "R9", "retired count", k, e_n);
        if (EXP_CYC >= 0)
          check(cyc == EXP_CYC, TAGC, "edges to done", cyc, EXP_CYC);
      end
      if (seen) begin
        post++;
        check(done, "R8", "done held", int'(done), 1);
        if (post == 4) fin_r = 1;
      end
    end
  end
endmodule

module line_pipe_core_tb_top;
  function automatic logic [27:0] mk(input logic [3:0] op, input logic [3:0] a,
                                     input logic [3:0] b, input logic [15:0] x);
    return {op, a, b, x};
  endfunction

  localparam logic [27:0] P_MAIN [11] = '{
    mk(3,1,0,1), mk(2,3,1,20), mk(3,2,0,2), mk(6,2,0,6), mk(1,2,1,16'h2000),
    mk(2,5,2,50), mk(2,6,1,20), mk(2,7,1,30), mk(4,7,0,10), mk(4,6,0,11),
    mk(4,5,0,12)};
  localparam logic [15:0] D_MAIN [16] = '{1: 16'd10, 2: 16'd5, default: 16'd0};
  localparam logic [27:0] P_LOOP [5] = '{
    mk(2,1,0,3), mk(2,2,2,5), mk(2,1,1,16'hFFFF), mk(6,1,0,2), mk(4,2,0,7)};
  localparam logic [27:0] P_LIN [6] = '{
    mk(2,1,0,3), mk(2,2,0,4), mk(5,0,0,6), mk(2,3,0,99), mk(2,4,0,98),
    mk(1,5,1,16'h2000)};
  localparam logic [27:0] P_DEP [3] = '{mk(2,1,0,1), mk(2,1,1,2), mk(2,1,1,4)};
  localparam logic [15:0] D_ZERO [16] = '{default: 16'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic m_done, p_done, l_done, d_done;
  logic [15:0] m_pc, p_pc, l_pc, d_pc;
  logic [4:0] m_occ, p_occ, l_occ, d_occ;
  logic m_rv, p_rv, l_rv, d_rv, m_we, p_we, l_we, d_we, m_st, p_st, l_st, d_st;
  logic [15:0] m_rl, p_rl, l_rl, d_rl, m_ra, p_ra, l_ra, d_ra, m_vl, p_vl, l_vl, d_vl;
  logic [3:0] m_rr, p_rr, l_rr, d_rr;
  int m_c, p_c, l_c, d_c, m_e, p_e, l_e, d_e;
  logic m_f, p_f, l_f, d_f;

  line_pipe_core dut_i (
    .clk(clk), .rst(rst), .done_o(m_done), .pc_o(m_pc), .occ_o(m_occ),
    .ret_valid_o(m_rv), .ret_line_o(m_rl), .ret_we_o(m_we), .ret_reg_o(m_rr),
    .ret_st_o(m_st), .ret_addr_o(m_ra), .ret_val_o(m_vl));
  line_pipe_core #(.NLINES(5), .PROG(P_LOOP), .DINIT(D_ZERO)) dut_loop_i (
    .clk(clk), .rst(rst), .done_o(p_done), .pc_o(p_pc), .occ_o(p_occ),
    .ret_valid_o(p_rv), .ret_line_o(p_rl), .ret_we_o(p_we), .ret_reg_o(p_rr),
    .ret_st_o(p_st), .ret_addr_o(p_ra), .ret_val_o(p_vl));
  line_pipe_core #(.NLINES(6), .PROG(P_LIN), .DINIT(D_ZERO)) dut_lin_i (
    .clk(clk), .rst(rst), .done_o(l_done), .pc_o(l_pc), .occ_o(l_occ),
    .ret_valid_o(l_rv), .ret_line_o(l_rl), .ret_we_o(l_we), .ret_reg_o(l_rr),
    .ret_st_o(l_st), .ret_addr_o(l_ra), .ret_val_o(l_vl));
  line_pipe_core #(.NLINES(3), .PROG(P_DEP), .DINIT(D_ZERO)) dut_dep_i (
    .clk(clk), .rst(rst), .done_o(d_done), .pc_o(d_pc), .occ_o(d_occ),
    .ret_valid_o(d_rv), .ret_line_o(d_rl), .ret_we_o(d_we), .ret_reg_o(d_rr),
    .ret_st_o(d_st), .ret_addr_o(d_ra), .ret_val_o(d_vl));

  lp_probe #(.NL(11), .PROG(P_MAIN), .DI(D_MAIN), .NAME("main")) pr_main (
    .clk(clk), .rst(rst), .done(m_done), .pc(m_pc), .occ(m_occ), .ret_valid(m_rv),
    .ret_line(m_rl), .ret_we(m_we), .ret_reg(m_rr), .ret_st(m_st), .ret_addr(m_ra),
    .ret_val(m_vl), .n_chk(m_c), .n_err(m_e), .fin(m_f));
  lp_probe #(.NL(5), .PROG(P_LOOP), .DI(D_ZERO), .NAME("loop")) pr_loop (
    .clk(clk), .rst(rst), .done(p_done), .pc(p_pc), .occ(p_occ), .ret_valid(p_rv),
    .ret_line(p_rl), .ret_we(p_we), .ret_reg(p_rr), .ret_st(p_st), .ret_addr(p_ra),
    .ret_val(p_vl), .n_chk(p_c), .n_err(p_e), .fin(p_f));
  // R7: jump penalty puts done at edge 14 (line 6 fetched on edge 8)
  lp_probe #(.NL(6), .PROG(P_LIN), .DI(D_ZERO), .EXP_CYC(14), .TAGC("R7"),
             .NAME("jump")) pr_lin (
    .clk(clk), .rst(rst), .done(l_done), .pc(l_pc), .occ(l_occ), .ret_valid(l_rv),
    .ret_line(l_rl), .ret_we(l_we), .ret_reg(l_rr), .ret_st(l_st), .ret_addr(l_ra),
    .ret_val(l_vl), .n_chk(l_c), .n_err(l_e), .fin(l_f));
  // R6: three chained lines take 3 + 6 + 2*2 = 13 edges
  lp_probe #(.NL(3), .PROG(P_DEP), .DI(D_ZERO), .EXP_CYC(13), .TAGC("R6"),
             .NAME("chain")) pr_dep (
    .clk(clk), .rst(rst), .done(d_done), .pc(d_pc), .occ(d_occ), .ret_valid(d_rv),
    .ret_line(d_rl), .ret_we(d_we), .ret_reg(d_rr), .ret_st(d_st), .ret_addr(d_ra),
    .ret_val(d_vl), .n_chk(d_c), .n_err(d_e), .fin(d_f));

  int tchk = 0, terr = 0;

  task automatic tcheck(input bit ok, input string req, input string what,
                        input int act, input int exp);
    tchk++;
    if (!ok) begin
      terr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    int wd;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    repeat (5) @(negedge clk);
    // after edge 5: chain has L3 in decode, L2 held in operand read, bubble, L1 in write-back
    tcheck(d_occ == 5'b10110, "R6", "chain occupancy edge 5", int'(d_occ), 5'b10110);
    tcheck(d_pc == 16'd4, "R10", "chain pc edge 5", int'(d_pc), 4);
    @(negedge clk);
    tcheck(l_occ == 5'b11111, "R10", "jump occupancy edge 6", int'(l_occ), 5'b11111);
    tcheck(l_pc == 16'd7, "R5", "jump pc edge 6", int'(l_pc), 7);
    @(negedge clk);
    tcheck(l_occ == 5'b10000, "R7", "occupancy after flush", int'(l_occ), 5'b10000);
    tcheck(l_pc == 16'd6, "R7", "pc after flush", int'(l_pc), 6);
    wd = 0;
    while (!(m_f && p_f && l_f && d_f) && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 5000) begin
      tchk++; terr++;
      $display("FAIL R8 watchdog: got %0d expected %0d", wd, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             tchk + m_c + p_c + l_c + d_c, terr + m_e + p_e + l_e + d_e);
    $finish;
  end
endmodule